// File: doc/BRIEF.md
# Sectored Cache Fill and Replacement Controller

This block keeps the tag store and per-line state of a small two-way set-associative data cache whose ways each hold one tag for a sector of two 32-byte lines. It takes one lookup at a time, described by a set index, a tag, a half-select bit that picks a line inside the sector, and a read/write flag. One clock later it reports whether the access hit, needs a fill of just the requested line because the tag is present but that line is invalid, or needs a fill of a freshly allocated sector because no tag matched.

For a fill the block stays busy until the data path signals that the 32-byte burst has arrived. It then writes the new tag and line state in a single clock. A new sector evicts the sibling line. A single-line fill leaves the sibling as it was. Victim ways are picked by allocation order, and each modified line of a displaced sector is announced as a copyback request toward a one-line writeback buffer. These requests go out while the new line is being read in. Data storage, bus signalling and snooping are handled elsewhere.

Top module: `scache_fill_ctrl`

## Requirements
- R1: After reset no line is valid or modified, every allocation pointer selects way 0, and res_valid_o, busy_o and cb_valid_o are low.
- R2: An accepted request whose tag matches a way holding at least one valid line, and whose requested line is valid, gives res_valid_o high for one cycle in the clock after acceptance, with res_kind_o = 0 (hit) and res_way_o the matching way. A read hit changes no state.
- R3: A write hit sets the modified bit of the requested line only.
- R4: A matching tag with an invalid requested line gives res_kind_o = 1. On commit that line becomes valid, its modified bit takes the request's write flag, and the sibling line keeps its valid and modified state. No copyback is requested.
- R5: When no way matches, the result is res_kind_o = 2. On commit the victim way takes the new tag, the requested line becomes valid with modified equal to the write flag, and the sibling line becomes invalid and clean.
- R6: The victim for res_kind_o = 2 is way 0 if it has no valid line, else way 1 if it has no valid line, else the way named by the set's allocation pointer.
- R7: A commit with res_kind_o = 2 into way w sets that set's pointer to the other way. Hits, single-line fills and ignored inputs never change a pointer.
- R8: For res_kind_o = 2, each victim line that is both valid and modified yields one cb_valid_o pulse carrying the victim's old tag, the set and the half (cb_half_o). Half 0 goes out in the cycle the result appears, and half 1 follows in the next cycle if half 0 was also sent, otherwise in that first cycle.
- R9: After a fill result busy_o stays high until fill_done_i is sampled high. Requests arriving while busy produce no result and change no state. fill_done_i is ignored while not busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Lookup request, accepted when not busy |
| req_write_i | input | 1 | Request is a write |
| req_set_i | input | SET_W | Set index |
| req_tag_i | input | TAG_W | Sector tag |
| req_half_i | input | 1 | Line within the sector |
| fill_done_i | input | 1 | Burst for the pending fill has arrived |
| res_valid_o | output | 1 | Lookup result valid |
| res_kind_o | output | 2 | 0 hit, 1 tag-hit fill, 2 tag-miss fill |
| res_way_o | output | 1 | Hit or victim way |
| busy_o | output | 1 | Fill pending |
| cb_valid_o | output | 1 | Copyback request for one line |
| cb_set_o | output | SET_W | Copyback set |
| cb_tag_o | output | TAG_W | Tag of the displaced sector |
| cb_half_o | output | 1 | Line within the displaced sector |

## Verification
A directed opening walks one set through an empty-way miss, a write hit, a single-line fill of the sibling, a miss into the other invalid way and a pointer-chosen eviction of a dirty sector. These steps separate the three result kinds, the invalid-way preference from the pointer, and a one-line copyback from a two-line one. A long sweep then draws sets, tags from a pool of three per set, halves and write flags. Tag conflicts and dirty evictions therefore come up often, and a reference model predicts every result kind, way and copyback pulse. Requests and fill-done strobes are injected at random into busy and idle windows, and later lookups show whether they disturbed any state.

// File: rtl/scache_pkg.sv
package scache_pkg;
  typedef enum logic [1:0] {
    K_HIT     = 2'd0,
    K_TAGHIT  = 2'd1,
    K_TAGMISS = 2'd2
  } kind_e;
endpackage

// File: rtl/scache_lookup.sv
module scache_lookup #(
  parameter int TAG_W = 8
) (
  input  logic [1:0][TAG_W-1:0] set_tags_i,
  input  logic [1:0][1:0]       set_lv_i,    // [way][half]
  input  logic [TAG_W-1:0]      req_tag_i,
  input  logic                  req_half_i,
  input  logic                  ptr_i,
  output logic                  match_o,
  output logic                  match_way_o,
  output logic                  line_valid_o,
  output logic                  victim_o
);
  logic [1:0] way_live, way_hit;

  for (genvar w = 0; w < 2; w++) begin : g_way
    assign way_live[w] = |set_lv_i[w];
    assign way_hit[w]  = way_live[w] && (set_tags_i[w] == req_tag_i);
  end

  assign match_o      = |way_hit;
  assign match_way_o  = !way_hit[0];
  assign line_valid_o = set_lv_i[match_way_o][req_half_i];

  always_comb begin
    if (!way_live[0])      victim_o = 1'b0;
    else if (!way_live[1]) victim_o = 1'b1;
    else                   victim_o = ptr_i;
  end
endmodule

// File: rtl/scache_cb_queue.sv
module scache_cb_queue #(
  parameter int SET_W = 2,
  parameter int TAG_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [1:0]       mask_i,
  input  logic [SET_W-1:0] set_i,
  input  logic [TAG_W-1:0] tag_i,
  output logic             cb_valid_o,
  output logic [SET_W-1:0] cb_set_o,
  output logic [TAG_W-1:0] cb_tag_o,
  output logic             cb_half_o
);
  logic [1:0]       pend_q;
  logic [SET_W-1:0] set_q;
  logic [TAG_W-1:0] tag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      set_q  <= '0;
      tag_q  <= '0;
    end else if (load_i) begin
      pend_q <= mask_i;
      set_q  <= set_i;
      tag_q  <= tag_i;
    end else if (pend_q[0]) begin
      pend_q[0] <= 1'b0;
    end else begin
      pend_q[1] <= 1'b0;
    end
  end

  assign cb_valid_o = |pend_q;
  assign cb_half_o  = !pend_q[0];
  assign cb_set_o   = set_q;
  assign cb_tag_o   = tag_q;

  // R8: each cycle without a load retires one pending line
  p_cb_drain_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cb_valid_o && !load_i) |=> ($countones(pend_q) < $past($countones(pend_q))));
endmodule

// File: rtl/scache_fill_ctrl.sv
module scache_fill_ctrl
  import scache_pkg::*;
#(
  parameter int NUM_SETS = 4,
  parameter int TAG_W    = 8,
  localparam int SET_W   = $clog2(NUM_SETS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic             req_write_i,
  input  logic [SET_W-1:0] req_set_i,
  input  logic [TAG_W-1:0] req_tag_i,
  input  logic             req_half_i,
  input  logic             fill_done_i,
  output logic             res_valid_o,
  output logic [1:0]       res_kind_o,
  output logic             res_way_o,
  output logic             busy_o,
  output logic             cb_valid_o,
  output logic [SET_W-1:0] cb_set_o,
  output logic [TAG_W-1:0] cb_tag_o,
  output logic             cb_half_o
);
  logic [NUM_SETS-1:0][1:0][TAG_W-1:0] tag_q;
  logic [NUM_SETS-1:0][1:0][1:0]       lv_q, md_q;   // [set][way][half]
  logic [NUM_SETS-1:0]                 ptr_q;

  logic             busy_q, res_valid_q, res_way_q, res_half_q;
  logic [SET_W-1:0] res_set_q;
  kind_e            res_kind_q;

  kind_e            pnd_kind_q;
  logic [SET_W-1:0] pnd_set_q;
  logic [TAG_W-1:0] pnd_tag_q;
  logic             pnd_way_q, pnd_half_q, pnd_write_q;

  logic  match, match_way, line_valid, victim, accept, commit, sel_way;
  kind_e kind;

  scache_lookup #(.TAG_W(TAG_W)) u_lookup (
    .set_tags_i  (tag_q[req_set_i]),
    .set_lv_i    (lv_q[req_set_i]),
    .req_tag_i   (req_tag_i),
    .req_half_i  (req_half_i),
    .ptr_i       (ptr_q[req_set_i]),
    .match_o     (match),
    .match_way_o (match_way),
    .line_valid_o(line_valid),
    .victim_o    (victim)
  );

  always_comb begin
    if (match && line_valid) kind = K_HIT;
    else if (match)          kind = K_TAGHIT;
    else                     kind = K_TAGMISS;
  end

  assign sel_way = match ? match_way : victim;
  assign accept  = req_valid_i && !busy_q;
  assign commit  = fill_done_i && busy_q;

  scache_cb_queue #(.SET_W(SET_W), .TAG_W(TAG_W)) u_cb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (accept && (kind == K_TAGMISS)),
    .mask_i    (lv_q[req_set_i][victim] & md_q[req_set_i][victim]),
    .set_i     (req_set_i),
    .tag_i     (tag_q[req_set_i][victim]),
    .cb_valid_o(cb_valid_o),
    .cb_set_o  (cb_set_o),
    .cb_tag_o  (cb_tag_o),
    .cb_half_o (cb_half_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_q <= 1'b0;
      res_kind_q  <= K_HIT;
      res_way_q   <= 1'b0;
      res_set_q   <= '0;
      res_half_q  <= 1'b0;
    end else begin
      res_valid_q <= accept;
      if (accept) begin
        res_kind_q <= kind;
        res_way_q  <= sel_way;
        res_set_q  <= req_set_i;
        res_half_q <= req_half_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q      <= 1'b0;
      pnd_kind_q  <= K_HIT;
      pnd_set_q   <= '0;
      pnd_tag_q   <= '0;
      pnd_way_q   <= 1'b0;
      pnd_half_q  <= 1'b0;
      pnd_write_q <= 1'b0;
    end else if (accept && kind != K_HIT) begin
      busy_q      <= 1'b1;
      pnd_kind_q  <= kind;
      pnd_set_q   <= req_set_i;
      pnd_tag_q   <= req_tag_i;
      pnd_way_q   <= sel_way;
      pnd_half_q  <= req_half_i;
      pnd_write_q <= req_write_i;
    end else if (commit) begin
      busy_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tag_q <= '0;
      lv_q  <= '0;
      md_q  <= '0;
      ptr_q <= '0;
    end else if (accept && kind == K_HIT) begin
      if (req_write_i) md_q[req_set_i][sel_way][req_half_i] <= 1'b1;
    end else if (commit) begin
      lv_q[pnd_set_q][pnd_way_q][pnd_half_q] <= 1'b1;
      md_q[pnd_set_q][pnd_way_q][pnd_half_q] <= pnd_write_q;
      if (pnd_kind_q == K_TAGMISS) begin
        tag_q[pnd_set_q][pnd_way_q]              <= pnd_tag_q;
        lv_q[pnd_set_q][pnd_way_q][!pnd_half_q]  <= 1'b0;
        md_q[pnd_set_q][pnd_way_q][!pnd_half_q]  <= 1'b0;
        ptr_q[pnd_set_q]                         <= !pnd_way_q;
      end
    end
  end

  assign res_valid_o = res_valid_q;
  assign res_kind_o  = res_kind_q;
  assign res_way_o   = res_way_q;
  assign busy_o      = busy_q;

  // R2: a reported hit names a valid line
  p_hit_line_valid_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && res_kind_o == K_HIT) |-> lv_q[res_set_q][res_way_q][res_half_q]);

  // R5: a new sector leaves its sibling line invalid
  p_sibling_cleared_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit && pnd_kind_q == K_TAGMISS) |=>
      !lv_q[$past(pnd_set_q)][$past(pnd_way_q)][!$past(pnd_half_q)]);

  // R7: pointers move only on a new-sector commit
  p_ptr_stable_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(commit && pnd_kind_q == K_TAGMISS) |=> $stable(ptr_q));

  // R9: no result while a fill is outstanding
  p_busy_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !fill_done_i) |=> (busy_o && !res_valid_o));

  // R9: a fill result always raises busy
  p_fill_sets_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && res_kind_o != K_HIT) |-> busy_o);
endmodule

// File: tb/scache_fill_ctrl_bench.sv
module scache_fill_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_SETS   = 4;
  localparam int TAG_W      = 8;
  localparam int SET_W      = 2;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             req_valid_i = 1'b0, req_write_i = 1'b0, req_half_i = 1'b0;
  logic [SET_W-1:0] req_set_i = '0;
  logic [TAG_W-1:0] req_tag_i = '0;
  logic             fill_done_i = 1'b0;
  logic             res_valid_o, res_way_o, busy_o, cb_valid_o, cb_half_o;
  logic [1:0]       res_kind_o;
  logic [SET_W-1:0] cb_set_o;
  logic [TAG_W-1:0] cb_tag_o;

  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  // reference model
  bit mv [NUM_SETS][2][2];
  bit mm [NUM_SETS][2][2];
  int mt [NUM_SETS][2];
  bit mp [NUM_SETS];

  scache_fill_ctrl #(.NUM_SETS(NUM_SETS), .TAG_W(TAG_W)) u_scache_fill_ctrl (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_op(input int s, input int t, input bit h, input bit w,
                       input bit poke_busy, input bit poke_idle);
    bit live0, live1, m0, m1, mw, vw, lvld;
    int kind, way, ncb;
    bit cbh [2];
    string ktag;
    live0 = mv[s][0][0] | mv[s][0][1];
    live1 = mv[s][1][0] | mv[s][1][1];
    m0 = live0 && mt[s][0] == t;
    m1 = live1 && mt[s][1] == t;
    mw = m0 ? 1'b0 : 1'b1;
    vw = !live0 ? 1'b0 : (!live1 ? 1'b1 : mp[s]);
    if (m0 || m1) begin
      way = mw; lvld = mv[s][mw][h];
      kind = lvld ? 0 : 1;
    end else begin
      way = vw; kind = 2;
    end
    ktag = (kind == 0) ? "R2 kind" : (kind == 1) ? "R4 kind" : "R5 kind";
    ncb = 0;
    if (kind == 2) for (int hh = 0; hh < 2; hh++)
      if (mv[s][vw][hh] && mm[s][vw][hh]) begin cbh[ncb] = hh[0]; ncb++; end

    @(negedge clk_i);
    req_valid_i = 1; req_set_i = s[SET_W-1:0]; req_tag_i = t[TAG_W-1:0];
    req_half_i = h; req_write_i = w;
    @(negedge clk_i);
    req_valid_i = 0;
    check("R2 res_valid", res_valid_o, 1);
    check(ktag, res_kind_o, kind);
    check((kind == 2 && live0 && live1) ? "R7 victim way" : "R6 way", res_way_o, way);
    if (kind == 0) begin
      check("R8 no copyback on hit", cb_valid_o, 0);
      if (w) mm[s][mw][h] = 1;
      if (poke_idle) begin
        fill_done_i = 1;  // R9: ignored when idle
        @(negedge clk_i);
        fill_done_i = 0;
        check("R9 idle fill_done", busy_o, 0);
      end
      return;
    end
    check("R9 busy", busy_o, 1);
    if (ncb >= 1) begin
      check("R8 cb valid 1", cb_valid_o, 1);
      check("R8 cb half 1", cb_half_o, cbh[0]);
      check("R8 cb tag", cb_tag_o, mt[s][vw]);
      check("R8 cb set", cb_set_o, s);
    end else check("R8 no cb", cb_valid_o, 0);
    if (poke_busy) begin
      req_valid_i = 1; req_tag_i = req_tag_i + 8'd1; req_write_i = 1;
    end
    @(negedge clk_i);
    req_valid_i = 0;
    if (poke_busy) check("R9 ignored while busy", res_valid_o, 0);
    if (ncb == 2) begin
      check("R8 cb valid 2", cb_valid_o, 1);
      check("R8 cb half 2", cb_half_o, cbh[1]);
    end else check("R8 cb done", cb_valid_o, 0);
    check("R9 still busy", busy_o, 1);
    fill_done_i = 1;
    @(negedge clk_i);
    fill_done_i = 0;
    check("R9 busy cleared", busy_o, 0);
    mv[s][way][h] = 1; mm[s][way][h] = w;
    if (kind == 2) begin
      mt[s][way] = t;
      mv[s][way][!h] = 0; mm[s][way][!h] = 0;
      mp[s] = !way[0];
    end
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R1: reset state
    check("R1 res_valid", res_valid_o, 0);
    check("R1 busy", busy_o, 0);
    check("R1 cb_valid", cb_valid_o, 0);
    rst_ni = 1;
    @(negedge clk_i);
    check("R1 after release", res_valid_o | busy_o | cb_valid_o, 0);
    // directed walk on set 0
    do_op(0, 10, 0, 0, 0, 0); // empty ways: miss into way 0 (R6)
    do_op(0, 10, 0, 1, 0, 1); // write hit, R3 marks half 0 dirty
    do_op(0, 10, 1, 0, 1, 0); // tag-hit fill of half 1 (R4)
    do_op(0, 20, 1, 1, 0, 0); // miss into invalid way 1
    do_op(0, 30, 0, 0, 0, 0); // pointer picks way 0; R3 seen via one copyback
    do_op(0, 20, 0, 1, 0, 0); // tag-hit fill, dirty sibling kept
    do_op(0, 40, 0, 0, 0, 0); // evict way 1: two copybacks
    // sweep
    for (int i = 0; i < 3000; i++) begin
      int s, t;
      s = $urandom_range(0, NUM_SETS - 1);
      t = 16 * s + $urandom_range(1, 3);
      do_op(s, t, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
            ($urandom_range(0, 3) == 0), ($urandom_range(0, 3) == 0));
    end
    // R7: final lookup of every set checks pointer-driven victims
    for (int s = 0; s < NUM_SETS; s++) do_op(s, 200 + s, 0, 0, 0, 0);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule